// File: doc/BRIEF.md
# Single-Cycle Load/Store Processor Core

This block is a processor core that completes one instruction per clock. It handles six instructions of a 32-bit load/store instruction set: register add, add-immediate, word load, word store, branch-if-equal and absolute jump. On every cycle the program counter addresses an internal instruction array. The fetched word is decoded, and its operands are read from a 32-entry register file. The ALU forms a sum, and the result is committed at the next rising edge: to a register, to the internal data array, or to the program counter. Both memories are plain word arrays with combinational reads, so the core runs on its own with no external memory model.

A program is written into the instruction array through a word-wide load port while the core is held in reset. Releasing reset starts execution at address 0. Each register write-back and each store is visible on observation ports during the cycle in which it takes effect. An environment can therefore follow execution without reaching into the core.

Top module: `sc_core`

## Requirements
- R1: While `rst_n` is low, no register write or store is reported or performed. After any rising edge with `rst_n` low, the PC is 0 and every register holds 0.
- R2: Register add is opcode 0x00 with funct 0x20, laid out as opcode[31:26], rs[25:21], rt[20:16], rd[15:11], funct[5:0]. It writes rs+rt, modulo 2^32, to rd.
- R3: Add-immediate is opcode 0x08, laid out as opcode[31:26], rs[25:21], rt[20:16], imm[15:0]. It writes rs plus the sign-extended imm to rt.
- R4: Word load is opcode 0x23. It writes to rt the data word at byte address rs+sext(imm), and a load returns what an earlier store left at that word.
- R5: Word store is opcode 0x2B. It writes the rt value to the data word at byte address rs+sext(imm) and performs no register write.
- R6: Branch-if-equal is opcode 0x04. When rs equals rt, the next PC is PC+4+(sext(imm)<<2); otherwise it is PC+4. Neither case writes a register or memory.
- R7: Jump is opcode 0x02 with a 26-bit target in bits [25:0]. The next PC is {(PC+4)[31:28], target, 2'b00}, and nothing is written.
- R8: Register 0 always reads as 0. A write aimed at it is dropped and is not reported on the write-back port.
- R9: Any other opcode, or opcode 0x00 with a funct other than 0x20, writes nothing and advances the PC by 4.
- R10: Outside a taken branch or a jump, the PC advances by 4 each cycle and stays word-aligned. The instruction array word at `load_addr` takes `load_data` at a rising edge with `load_we` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| load_we | input | 1 | Write strobe for the instruction array |
| load_addr | input | $clog2(IMEM_WORDS) | Word index written by the load port |
| load_data | input | 32 | Instruction word to store |
| pc_o | output | 32 | Current program counter |
| insn_o | output | 32 | Instruction fetched at `pc_o` |
| wb_en_o | output | 1 | A register write happens at the next edge |
| wb_reg_o | output | 5 | Destination register of that write |
| wb_data_o | output | 32 | Value written |
| st_en_o | output | 1 | A data-array store happens at the next edge |
| st_addr_o | output | 32 | Byte address of the store |
| st_data_o | output | 32 | Word stored |

## Verification
The assertions check the following on every cycle. The core never reports a store and a register write together, and never reports a write to register 0. Nothing is written during reset, and reset leaves the PC at 0. The PC stays word-aligned, steps by 4 after any non-control instruction, and lands on the jump target after a jump. Only the bench's directed programs can show the values themselves: sign extension, wrapping sums, a load returning earlier stored data, branch targets in both directions, and the register file cleared by a reset taken mid-program.

// File: rtl/sc_pkg.sv
// Package sc_pkg
// Shared widths, opcode and funct codes, and the decoded control bundle of
// the single-cycle core. Assumes the fixed 32-bit instruction format.
package sc_pkg;

    localparam int XLEN   = 32;
    localparam int NREGS  = 32;
    localparam int RIDX_W = $clog2(NREGS);

    localparam logic [5:0] OPC_RTYPE = 6'h00;
    localparam logic [5:0] OPC_JMP   = 6'h02;
    localparam logic [5:0] OPC_BEQ   = 6'h04;
    localparam logic [5:0] OPC_ADDI  = 6'h08;
    localparam logic [5:0] OPC_LW    = 6'h23;
    localparam logic [5:0] OPC_SW    = 6'h2B;
    localparam logic [5:0] FN_ADD    = 6'h20;

    typedef struct packed {
        logic reg_we;    // instruction writes a register
        logic dst_rd;    // destination is rd (else rt)
        logic opb_imm;   // ALU second operand is the sign-extended immediate
        logic wd_mem;    // write-back data comes from the data array
        logic mem_we;    // instruction stores a word
        logic is_beq;    // conditional branch
        logic is_jmp;    // absolute jump
    } ctrl_t;

endpackage

// File: rtl/sc_decode.sv
// Module sc_decode
// Turns opcode and funct into the datapath control bundle. Any code outside
// the supported subset yields an all-zero bundle, which behaves as a no-op.
module sc_decode
    import sc_pkg::*;
(
    input  logic [5:0] opcode,
    input  logic [5:0] funct,
    output ctrl_t      ctrl
);

    // Purpose: one control pattern per supported instruction.
    always_comb begin
        ctrl = '0;
        case (opcode)
            OPC_RTYPE: begin
                if (funct == FN_ADD) begin
                    ctrl.reg_we = 1'b1;
                    ctrl.dst_rd = 1'b1;
                end
            end
            OPC_ADDI: begin
                ctrl.reg_we  = 1'b1;
                ctrl.opb_imm = 1'b1;
            end
            OPC_LW: begin
                ctrl.reg_we  = 1'b1;
                ctrl.opb_imm = 1'b1;
                ctrl.wd_mem  = 1'b1;
            end
            OPC_SW: begin
                ctrl.opb_imm = 1'b1;
                ctrl.mem_we  = 1'b1;
            end
            OPC_BEQ: ctrl.is_beq = 1'b1;
            OPC_JMP: ctrl.is_jmp = 1'b1;
            default: ctrl = '0;
        endcase
    end

endmodule

// File: rtl/sc_regfile.sv
// Module sc_regfile
// Register array with two combinational read ports and one write port that
// is taken on the rising edge. Entry 0 is a constant zero with no storage.
// A synchronous active-low reset clears every stored entry.
module sc_regfile #(
    parameter int N = 32,
    parameter int W = 32,
    localparam int AW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic [AW-1:0] raddr_a,
    output logic [W-1:0]  rdata_a,
    input  logic [AW-1:0] raddr_b,
    output logic [W-1:0]  rdata_b
);

    logic [W-1:0] entry [N];

    for (genvar gi = 0; gi < N; gi++) begin : g_entry
        if (gi == 0) begin : g_zero
            assign entry[gi] = '0;
        end else begin : g_store
            // Purpose: hold one register; cleared by reset, loaded on a matching write.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    entry[gi] <= '0;
                end else if (we && (waddr == AW'(gi))) begin
                    entry[gi] <= wdata;
                end
            end
        end
    end

    assign rdata_a = entry[raddr_a];
    assign rdata_b = entry[raddr_b];

endmodule

// File: rtl/sc_alu.sv
// Module sc_alu
// The ALU of this subset: a wrapping adder, plus an equality flag on the
// raw operands that the branch uses.
module sc_alu #(
    parameter int W = 32
) (
    input  logic [W-1:0] opa,
    input  logic [W-1:0] opb,
    output logic [W-1:0] sum,
    output logic         equal
);

    assign sum   = opa + opb;
    assign equal = (opa == opb);

endmodule

// File: rtl/sc_nextpc.sv
// Module sc_nextpc
// Picks the next program counter: sequential, PC-relative branch, or
// absolute jump. Assumes 32-bit byte addresses and word-aligned instructions.
module sc_nextpc (
    input  logic [31:0] pc,
    input  logic [15:0] imm,
    input  logic [25:0] target,
    input  logic        is_beq,
    input  logic        equal,
    input  logic        is_jmp,
    output logic [31:0] next_pc
);

    logic [31:0] pc_plus4;
    logic [31:0] br_target;
    logic [31:0] jmp_target;

    assign pc_plus4   = pc + 32'd4;
    assign br_target  = pc_plus4 + {{14{imm[15]}}, imm, 2'b00};
    assign jmp_target = {pc_plus4[31:28], target, 2'b00};

    // Purpose: priority of jump over a taken branch over the sequential path.
    always_comb begin
        if (is_jmp) begin
            next_pc = jmp_target;
        end else if (is_beq && equal) begin
            next_pc = br_target;
        end else begin
            next_pc = pc_plus4;
        end
    end

endmodule

// File: rtl/sc_core.sv
// Module sc_core
// Single-cycle core for the add/addi/lw/sw/beq/j subset. It holds the PC,
// the instruction and data arrays (combinational reads, writes on the rising
// edge) and ties decode, register file, ALU and next-PC logic together.
// Assumes programs are written through the load port while rst_n is low.
module sc_core
    import sc_pkg::*;
#(
    parameter int IMEM_WORDS = 64,
    parameter int DMEM_WORDS = 64,
    localparam int IA_W = $clog2(IMEM_WORDS),
    localparam int DA_W = $clog2(DMEM_WORDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_we,
    input  logic [IA_W-1:0]   load_addr,
    input  logic [31:0]       load_data,
    output logic [31:0]       pc_o,
    output logic [31:0]       insn_o,
    output logic              wb_en_o,
    output logic [RIDX_W-1:0] wb_reg_o,
    output logic [XLEN-1:0]   wb_data_o,
    output logic              st_en_o,
    output logic [XLEN-1:0]   st_addr_o,
    output logic [XLEN-1:0]   st_data_o
);

    logic [31:0]       pc_q;
    logic [31:0]       pc_next;
    logic [31:0]       imem [IMEM_WORDS];
    logic [XLEN-1:0]   dmem [DMEM_WORDS];
    logic [31:0]       insn;
    ctrl_t             ctrl;
    logic [RIDX_W-1:0] rs_idx, rt_idx, rd_idx, dst_idx;
    logic [15:0]       imm16;
    logic [XLEN-1:0]   imm_sx;
    logic [XLEN-1:0]   rs_val, rt_val, alu_b, alu_sum, load_val, wdata;
    logic              alu_eq;
    logic              rf_we;
    logic              mem_we;

    // Purpose: program counter, reset to address 0.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_q <= '0;
        end else begin
            pc_q <= pc_next;
        end
    end

    // Purpose: instruction array written by the load port.
    always_ff @(posedge clk) begin
        if (load_we) begin
            imem[load_addr] <= load_data;
        end
    end

    assign insn   = imem[pc_q[IA_W+1:2]];
    assign rs_idx = insn[25:21];
    assign rt_idx = insn[20:16];
    assign rd_idx = insn[15:11];
    assign imm16  = insn[15:0];
    assign imm_sx = {{(XLEN-16){imm16[15]}}, imm16};

    sc_decode i_decode (
        .opcode (insn[31:26]),
        .funct  (insn[5:0]),
        .ctrl   (ctrl)
    );

    assign dst_idx = ctrl.dst_rd ? rd_idx : rt_idx;
    assign rf_we   = rst_n && ctrl.reg_we && (dst_idx != '0);
    assign mem_we  = rst_n && ctrl.mem_we;

    sc_regfile #(
        .N (NREGS),
        .W (XLEN)
    ) i_regfile (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (rf_we),
        .waddr   (dst_idx),
        .wdata   (wdata),
        .raddr_a (rs_idx),
        .rdata_a (rs_val),
        .raddr_b (rt_idx),
        .rdata_b (rt_val)
    );

    assign alu_b = ctrl.opb_imm ? imm_sx : rt_val;

    sc_alu #(
        .W (XLEN)
    ) i_alu (
        .opa   (rs_val),
        .opb   (alu_b),
        .sum   (alu_sum),
        .equal (alu_eq)
    );

    // Purpose: data array, one word store per cycle.
    always_ff @(posedge clk) begin
        if (mem_we) begin
            dmem[alu_sum[DA_W+1:2]] <= rt_val;
        end
    end

    assign load_val = dmem[alu_sum[DA_W+1:2]];
    assign wdata    = ctrl.wd_mem ? load_val : alu_sum;

    sc_nextpc i_nextpc (
        .pc      (pc_q),
        .imm     (imm16),
        .target  (insn[25:0]),
        .is_beq  (ctrl.is_beq),
        .equal   (alu_eq),
        .is_jmp  (ctrl.is_jmp),
        .next_pc (pc_next)
    );

    assign pc_o      = pc_q;
    assign insn_o    = insn;
    assign wb_en_o   = rf_we;
    assign wb_reg_o  = dst_idx;
    assign wb_data_o = wdata;
    assign st_en_o   = mem_we;
    assign st_addr_o = alu_sum;
    assign st_data_o = rt_val;

endmodule

// File: rtl/sc_core_chk.sv
// Module sc_core_chk
// Cycle-by-cycle properties of the core, taken from its ports only and
// bound to every instance of sc_core.
module sc_core_chk
    import sc_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic [31:0] pc_o,
    input logic [31:0] insn_o,
    input logic        wb_en_o,
    input logic [4:0]  wb_reg_o,
    input logic        st_en_o
);

    // R1
    pc_reset_chk: assert property (@(posedge clk) !rst_n |=> (pc_o == 32'd0))
        else $error("pc not zero after reset");

    // R1
    no_write_in_reset_chk: assert property (@(posedge clk) !rst_n |-> (!wb_en_o && !st_en_o))
        else $error("write reported during reset");

    // R5
    store_no_wb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_en_o |-> !wb_en_o)
        else $error("store together with register write");

    // R8
    r0_never_written_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wb_en_o |-> (wb_reg_o != 5'd0))
        else $error("write to register 0 reported");

    // R10
    pc_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pc_o[1:0] == 2'b00)
        else $error("pc not word aligned");

    // R10
    pc_seq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (insn_o[31:26] != OPC_BEQ && insn_o[31:26] != OPC_JMP)
        |=> (pc_o == $past(pc_o) + 32'd4))
        else $error("pc did not step by 4");

    // R7
    jump_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (insn_o[31:26] == OPC_JMP)
        |=> (pc_o == {$past(pc_o[31:28] + {3'b000, &pc_o[27:2]}), $past(insn_o[25:0]), 2'b00}))
        else $error("jump target wrong");

endmodule

bind sc_core sc_core_chk i_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .pc_o     (pc_o),
    .insn_o   (insn_o),
    .wb_en_o  (wb_en_o),
    .wb_reg_o (wb_reg_o),
    .st_en_o  (st_en_o)
);

// File: tb/test_sc_core.sv
// Directed bench for sc_core: one task per scenario. Each task loads a small
// program while reset is held, releases reset, then samples the observation
// ports one nanosecond after every falling edge.
module test_sc_core;

    localparam int CLK_PERIOD = 10;
    localparam int PROG_LEN   = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        load_we = 1'b0;
    logic [5:0]  load_addr = '0;
    logic [31:0] load_data = '0;
    logic [31:0] pc_o, insn_o, wb_data_o, st_addr_o, st_data_o;
    logic        wb_en_o, st_en_o;
    logic [4:0]  wb_reg_o;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;
    logic [31:0] prog [PROG_LEN];

    always #(CLK_PERIOD/2) clk = ~clk;

    sc_core i_sc_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_we   (load_we),
        .load_addr (load_addr),
        .load_data (load_data),
        .pc_o      (pc_o),
        .insn_o    (insn_o),
        .wb_en_o   (wb_en_o),
        .wb_reg_o  (wb_reg_o),
        .wb_data_o (wb_data_o),
        .st_en_o   (st_en_o),
        .st_addr_o (st_addr_o),
        .st_data_o (st_data_o)
    );

    function automatic logic [31:0] enc_r(input logic [4:0] rs, rt, rd, input logic [5:0] fn);
        return {6'h00, rs, rt, rd, 5'd0, fn};
    endfunction
    function automatic logic [31:0] enc_i(input logic [5:0] op, input logic [4:0] rs, rt, input logic [15:0] imm);
        return {op, rs, rt, imm};
    endfunction
    function automatic logic [31:0] enc_j(input logic [25:0] tgt);
        return {6'h02, tgt};
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic clear_prog();
        for (int i = 0; i < PROG_LEN; i++) prog[i] = 32'h0;
    endtask

    // Hold reset, write the program through the load port, then release.
    task automatic boot();
        @(negedge clk);
        rst_n = 1'b0;
        for (int i = 0; i < PROG_LEN; i++) begin
            load_we   = 1'b1;
            load_addr = 6'(i);
            load_data = prog[i];
            @(negedge clk);
        end
        load_we = 1'b0;
        rst_n   = 1'b1;
        #1;
    endtask

    task automatic step();
        @(negedge clk);
        #1;
    endtask

    task automatic t_arith();
        clear_prog();
        prog[0] = enc_i(6'h08, 5'd0, 5'd1, 16'd5);
        prog[1] = enc_i(6'h08, 5'd0, 5'd2, 16'hFFFD);
        prog[2] = enc_r(5'd1, 5'd2, 5'd3, 6'h20);
        prog[3] = enc_i(6'h08, 5'd0, 5'd6, 16'hFFFF);
        prog[4] = enc_r(5'd6, 5'd6, 5'd7, 6'h20);
        boot();
        chk("R10 first pc", pc_o, 32'd0);
        chk("R10 fetched word matches loaded", insn_o, prog[0]);
        chk("R3 addi en", 32'(wb_en_o), 32'd1);
        chk("R3 addi dest rt", 32'(wb_reg_o), 32'd1);
        chk("R3 addi data", wb_data_o, 32'd5);
        step();
        chk("R3 addi negative imm", wb_data_o, 32'hFFFF_FFFD);
        chk("R10 pc step", pc_o, 32'd4);
        step();
        chk("R2 add dest rd", 32'(wb_reg_o), 32'd3);
        chk("R2 add sum", wb_data_o, 32'd2);
        step();
        step();
        chk("R2 add wraps", wb_data_o, 32'hFFFF_FFFE);
        chk("R10 pc after 4 steps", pc_o, 32'd16);
    endtask

    task automatic t_mem();
        clear_prog();
        prog[0] = enc_i(6'h08, 5'd0, 5'd1, 16'd100);
        prog[1] = enc_i(6'h08, 5'd0, 5'd2, 16'h1234);
        prog[2] = enc_i(6'h2B, 5'd1, 5'd2, 16'd8);
        prog[3] = enc_i(6'h2B, 5'd1, 5'd1, 16'hFFFC);
        prog[4] = enc_i(6'h23, 5'd1, 5'd3, 16'd8);
        prog[5] = enc_i(6'h23, 5'd0, 5'd4, 16'd96);
        prog[6] = enc_r(5'd3, 5'd4, 5'd5, 6'h20);
        boot();
        step();
        step();
        chk("R5 store en", 32'(st_en_o), 32'd1);
        chk("R5 store no wb", 32'(wb_en_o), 32'd0);
        chk("R5 store addr", st_addr_o, 32'd108);
        chk("R5 store data", st_data_o, 32'h1234);
        step();
        chk("R5 store negative offset addr", st_addr_o, 32'd96);
        chk("R5 store data rs", st_data_o, 32'd100);
        step();
        chk("R4 load en", 32'(wb_en_o), 32'd1);
        chk("R4 load dest", 32'(wb_reg_o), 32'd3);
        chk("R4 load data", wb_data_o, 32'h1234);
        chk("R4 load no store", 32'(st_en_o), 32'd0);
        step();
        chk("R4 load other base", wb_data_o, 32'd100);
        step();
        chk("R4 loaded values usable", wb_data_o, 32'h1298);
    endtask

    task automatic t_r0();
        clear_prog();
        prog[0] = enc_i(6'h08, 5'd0, 5'd0, 16'd9);
        prog[1] = enc_i(6'h08, 5'd0, 5'd1, 16'd4);
        prog[2] = enc_r(5'd1, 5'd1, 5'd0, 6'h20);
        prog[3] = enc_i(6'h2B, 5'd1, 5'd0, 16'd0);
        boot();
        chk("R8 addi to r0 not reported", 32'(wb_en_o), 32'd0);
        step();
        step();
        chk("R8 add to r0 not reported", 32'(wb_en_o), 32'd0);
        step();
        chk("R8 r0 reads zero", st_data_o, 32'd0);
        chk("R8 store addr from r1", st_addr_o, 32'd4);
    endtask

    task automatic t_branch();
        clear_prog();
        prog[0] = enc_i(6'h08, 5'd0, 5'd1, 16'd7);
        prog[1] = enc_i(6'h08, 5'd0, 5'd2, 16'd7);
        prog[2] = enc_i(6'h04, 5'd1, 5'd2, 16'd3);
        prog[3] = enc_i(6'h08, 5'd0, 5'd9, 16'd1);
        prog[4] = enc_i(6'h08, 5'd0, 5'd9, 16'd1);
        prog[5] = enc_i(6'h08, 5'd0, 5'd9, 16'd1);
        prog[6] = enc_i(6'h04, 5'd1, 5'd0, 16'hFFFB);
        prog[7] = enc_i(6'h04, 5'd0, 5'd0, 16'hFFF8);
        boot();
        step();
        step();
        chk("R6 branch no wb", 32'(wb_en_o), 32'd0);
        chk("R6 branch no store", 32'(st_en_o), 32'd0);
        step();
        chk("R6 taken forward", pc_o, 32'd24);
        step();
        chk("R6 not taken", pc_o, 32'd28);
        step();
        chk("R6 taken backward", pc_o, 32'd0);
        chk("R6 back at first insn", insn_o, prog[0]);
    endtask

    task automatic t_jump();
        clear_prog();
        prog[0] = enc_j(26'd5);
        prog[1] = enc_i(6'h08, 5'd0, 5'd8, 16'd1);
        prog[2] = enc_i(6'h08, 5'd0, 5'd3, 16'd33);
        prog[5] = enc_j(26'd2);
        boot();
        chk("R7 jump no wb", 32'(wb_en_o), 32'd0);
        step();
        chk("R7 jump forward", pc_o, 32'd20);
        step();
        chk("R7 jump backward", pc_o, 32'd8);
        chk("R7 landing insn runs", wb_data_o, 32'd33);
    endtask

    task automatic t_unsupported();
        clear_prog();
        prog[0] = 32'h0;
        prog[1] = enc_r(5'd0, 5'd0, 5'd4, 6'h22);
        prog[2] = enc_i(6'h0D, 5'd0, 5'd1, 16'h00FF);
        prog[3] = enc_i(6'h08, 5'd0, 5'd1, 16'd1);
        boot();
        chk("R9 funct 0 no wb", 32'(wb_en_o), 32'd0);
        chk("R9 funct 0 no store", 32'(st_en_o), 32'd0);
        step();
        chk("R9 funct 0x22 no wb", 32'(wb_en_o), 32'd0);
        chk("R9 pc advanced", pc_o, 32'd4);
        step();
        chk("R9 opcode 0x0D no wb", 32'(wb_en_o), 32'd0);
        chk("R9 opcode 0x0D no store", 32'(st_en_o), 32'd0);
        step();
        chk("R9 supported insn after", wb_data_o, 32'd1);
        chk("R9 pc after no-ops", pc_o, 32'd12);
    endtask

    task automatic t_reset();
        clear_prog();
        prog[0] = enc_i(6'h08, 5'd0, 5'd7, 16'd55);
        prog[1] = enc_i(6'h2B, 5'd0, 5'd7, 16'd0);
        boot();
        chk("R3 r7 written", wb_data_o, 32'd55);
        step();
        chk("R5 r7 stored", st_data_o, 32'd55);
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        chk("R1 store suppressed in reset", 32'(st_en_o), 32'd0);
        @(negedge clk);
        load_we   = 1'b1;
        load_addr = 6'd0;
        load_data = enc_i(6'h2B, 5'd0, 5'd7, 16'd4);
        #1;
        chk("R1 pc zero in reset", pc_o, 32'd0);
        chk("R1 wb suppressed in reset", 32'(wb_en_o), 32'd0);
        @(negedge clk);
        load_we = 1'b0;
        rst_n   = 1'b1;
        #1;
        chk("R10 reloaded word fetched", insn_o, enc_i(6'h2B, 5'd0, 5'd7, 16'd4));
        chk("R1 store after reset addr", st_addr_o, 32'd4);
        chk("R1 register cleared by reset", st_data_o, 32'd0);
    endtask

    initial begin
        t_arith();
        t_mem();
        t_r0();
        t_branch();
        t_jump();
        t_unsupported();
        t_reset();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule